// File: doc/BRIEF.md
# Scatter-Gather Vertex Pipeline

This block is the per-lane datapath of an edge-centric graph engine. It works against an on-chip interval buffer that holds the attributes of the vertices in the current partition. The buffer sits outside the block and is reached through one read port and one write port. The block takes one item per clock and runs it through three stages: vertex read, compute and vertex write.

A mode input sets what an item means. In scatter mode an item is an edge, given as source, destination and weight. The block fetches the source attribute and emits an update whose value is the weight times that attribute and whose destination is the destination of the edge. In gather mode an item is an update, given as destination and value. The block fetches the destination attribute, adds the value and writes the sum back into the buffer. At the same time it pulses a completion signal that carries the vertex index.

The buffer address of a vertex is its global index minus `part_idx * 2**IV_LOG2`, truncated to the buffer width. Attributes, weights and values are 32-bit unsigned integers.

Top module: `sgp_vertex_pipe`

## Requirements
- R1: While reset is asserted and right after it is released, `upd_valid`, `wr_en`, `done_valid` and `rd_en` are 0 and `in_ready` is 1.
- R2: In scatter mode (`mode`=0), an item accepted on an edge drives `rd_en`=1 and `rd_addr` = `in_src` − partition base during that same cycle. Its update appears with `upd_dst` = `in_dst` and `upd_val` = `in_val` × attribute, in the cycle that follows the second rising edge after acceptance.
- R3: A scatter item never causes `wr_en` or `done_valid`.
- R4: In gather mode (`mode`=1), an accepted item reads `rd_addr` = `in_dst` − partition base. In the cycle that follows the second rising edge after acceptance, the block drives `wr_en`=1, `wr_addr` equal to that address and `wr_data` = attribute + `in_val`. In the same cycle it drives `done_valid`=1 and `done_vidx` = `in_dst`.
- R5: A gather item never causes `upd_valid`.
- R6: Gather items that hit the same vertex one or two items apart accumulate every value. This holds although the buffer has a one-cycle read latency and returns the old data when a read and a write meet at the same address (read-first).
- R7: `in_ready` is 0 while an item of the other mode is still in the read or compute stage. A mode switch directly after an accepted item therefore waits exactly two cycles.
- R8: A stream of items of one mode is accepted at one item per clock with no wait cycles.
- R9: Products and sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 scatter, 1 gather |
| part_idx | input | PART_W | Index of the partition in the buffer |
| in_valid | input | 1 | Item present |
| in_ready | output | 1 | Item can be taken |
| in_src | input | 32 | Edge source vertex (scatter only) |
| in_dst | input | 32 | Destination vertex |
| in_val | input | 32 | Edge weight or update value |
| rd_en | output | 1 | Buffer read strobe |
| rd_addr | output | AW | Buffer read address |
| rd_data | input | 32 | Buffer read data, one cycle after rd_en |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | AW | Buffer write address |
| wr_data | output | 32 | Buffer write data |
| upd_valid | output | 1 | Update produced |
| upd_dst | output | 32 | Update destination vertex |
| upd_val | output | 32 | Update value |
| done_valid | output | 1 | Vertex write completed |
| done_vidx | output | 32 | Vertex index of that write |

## Verification
The buffer read request goes out combinationally in the accept cycle. Updates, buffer writes and completions come out two rising edges after acceptance. The bench therefore drives on falling edges and checks `rd_addr` just after it drives. It stores each expected result with the cycle number in which it is due, acceptance plus two, and the monitor on the falling edge compares both the value and that cycle number. Mode switches are checked by counting the falling edges on which a presented item was refused.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
  localparam int DW = 32;

  typedef enum logic {
    SG_SCATTER = 1'b0,
    SG_GATHER  = 1'b1
  } sg_mode_e;

  // update value produced from an edge
  function automatic logic [DW-1:0] edge_value(input logic [DW-1:0] weight,
                                               input logic [DW-1:0] attr);
    return weight * attr;
  endfunction

  // attribute after applying an update
  function automatic logic [DW-1:0] apply_value(input logic [DW-1:0] attr,
                                                input logic [DW-1:0] value);
    return attr + value;
  endfunction
endpackage

// File: rtl/sgp_read_stage.sv
module sgp_read_stage
  import sgp_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  sg_mode_e      mode,
  input  logic [DW-1:0] in_dst,
  input  logic [DW-1:0] in_val,
  input  logic [AW-1:0] dst_addr,
  output logic          s1_valid,
  output sg_mode_e      s1_mode,
  output logic [DW-1:0] s1_dst,
  output logic [DW-1:0] s1_val,
  output logic [AW-1:0] s1_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mode  <= SG_SCATTER;
      s1_dst   <= '0;
      s1_val   <= '0;
      s1_addr  <= '0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_mode <= mode;
        s1_dst  <= in_dst;
        s1_val  <= in_val;
        s1_addr <= dst_addr;
      end
    end
  end
endmodule

// File: rtl/sgp_compute_stage.sv
module sgp_compute_stage
  import sgp_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s1_valid,
  input  sg_mode_e      s1_mode,
  input  logic [DW-1:0] s1_dst,
  input  logic [DW-1:0] s1_val,
  input  logic [AW-1:0] s1_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          s3_valid,
  input  logic [AW-1:0] s3_addr,
  input  logic [DW-1:0] s3_data,
  output logic          s2_valid,
  output sg_mode_e      s2_mode,
  output logic [DW-1:0] s2_dst,
  output logic [AW-1:0] s2_addr,
  output logic [DW-1:0] s2_res
);
  logic          fwd_hit_s2;
  logic          fwd_hit_s3;
  logic [DW-1:0] operand;
  logic [DW-1:0] result;

  // a gather result not yet visible through the read-first buffer
  assign fwd_hit_s2 = (s1_mode == SG_GATHER) && s2_valid &&
                      (s2_mode == SG_GATHER) && (s2_addr == s1_addr);
  assign fwd_hit_s3 = (s1_mode == SG_GATHER) && s3_valid && (s3_addr == s1_addr);

  always_comb begin
    if (fwd_hit_s2)      operand = s2_res;
    else if (fwd_hit_s3) operand = s3_data;
    else                 operand = rd_data;
    if (s1_mode == SG_GATHER) result = apply_value(operand, s1_val);
    else                      result = edge_value(s1_val, operand);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_mode  <= SG_SCATTER;
      s2_dst   <= '0;
      s2_addr  <= '0;
      s2_res   <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_mode <= s1_mode;
        s2_dst  <= s1_dst;
        s2_addr <= s1_addr;
        s2_res  <= result;
      end
    end
  end
endmodule

// File: rtl/sgp_write_stage.sv
module sgp_write_stage
  import sgp_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s2_valid,
  input  sg_mode_e      s2_mode,
  input  logic [DW-1:0] s2_dst,
  input  logic [AW-1:0] s2_addr,
  input  logic [DW-1:0] s2_res,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          done_valid,
  output logic [DW-1:0] done_vidx,
  output logic          upd_valid,
  output logic [DW-1:0] upd_dst,
  output logic [DW-1:0] upd_val,
  output logic          s3_valid,
  output logic [AW-1:0] s3_addr,
  output logic [DW-1:0] s3_data
);
  logic write_evt;

  assign write_evt  = s2_valid && (s2_mode == SG_GATHER);
  assign wr_en      = write_evt;
  assign wr_addr    = s2_addr;
  assign wr_data    = s2_res;
  assign done_valid = write_evt;
  assign done_vidx  = s2_dst;
  assign upd_valid  = s2_valid && (s2_mode == SG_SCATTER);
  assign upd_dst    = s2_dst;
  assign upd_val    = s2_res;

  // copy of the last write, needed for one more cycle by the read-first buffer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s3_valid <= 1'b0;
      s3_addr  <= '0;
      s3_data  <= '0;
    end else begin
      s3_valid <= write_evt;
      if (write_evt) begin
        s3_addr <= s2_addr;
        s3_data <= s2_res;
      end
    end
  end
endmodule

// File: rtl/sgp_vertex_pipe.sv
module sgp_vertex_pipe
  import sgp_pkg::*;
#(
  parameter int IV_LOG2 = 4,
  parameter int PART_W  = 8,
  localparam int AW     = IV_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic [PART_W-1:0] part_idx,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_src,
  input  logic [31:0]       in_dst,
  input  logic [31:0]       in_val,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic [31:0]       rd_data,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [31:0]       wr_data,
  output logic              upd_valid,
  output logic [31:0]       upd_dst,
  output logic [31:0]       upd_val,
  output logic              done_valid,
  output logic [31:0]       done_vidx
);
  sg_mode_e      cur_mode;
  logic [DW-1:0] part_base;
  logic          accept;
  logic          mode_block;
  logic [AW-1:0] dst_addr;

  logic          s1_valid, s2_valid, s3_valid;
  sg_mode_e      s1_mode, s2_mode;
  logic [DW-1:0] s1_dst, s1_val, s2_dst, s2_res, s3_data;
  logic [AW-1:0] s1_addr, s2_addr, s3_addr;

  function automatic logic [AW-1:0] local_addr(input logic [DW-1:0] vidx,
                                               input logic [DW-1:0] base);
    return AW'(vidx - base);
  endfunction

  assign cur_mode   = sg_mode_e'(mode);
  assign part_base  = DW'(part_idx) << IV_LOG2;
  assign mode_block = (s1_valid && (s1_mode != cur_mode)) ||
                      (s2_valid && (s2_mode != cur_mode));
  assign in_ready   = !mode_block;
  assign accept     = in_valid && in_ready;
  assign dst_addr   = local_addr(in_dst, part_base);
  assign rd_en      = accept;
  assign rd_addr    = (cur_mode == SG_GATHER) ? dst_addr : local_addr(in_src, part_base);

  sgp_read_stage #(.AW(AW)) u_read (
    .clk(clk), .rst_n(rst_n), .accept(accept), .mode(cur_mode),
    .in_dst(in_dst), .in_val(in_val), .dst_addr(dst_addr),
    .s1_valid(s1_valid), .s1_mode(s1_mode), .s1_dst(s1_dst),
    .s1_val(s1_val), .s1_addr(s1_addr)
  );

  sgp_compute_stage #(.AW(AW)) u_comp (
    .clk(clk), .rst_n(rst_n),
    .s1_valid(s1_valid), .s1_mode(s1_mode), .s1_dst(s1_dst),
    .s1_val(s1_val), .s1_addr(s1_addr), .rd_data(rd_data),
    .s3_valid(s3_valid), .s3_addr(s3_addr), .s3_data(s3_data),
    .s2_valid(s2_valid), .s2_mode(s2_mode), .s2_dst(s2_dst),
    .s2_addr(s2_addr), .s2_res(s2_res)
  );

  sgp_write_stage #(.AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .s2_valid(s2_valid), .s2_mode(s2_mode), .s2_dst(s2_dst),
    .s2_addr(s2_addr), .s2_res(s2_res),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done_valid(done_valid), .done_vidx(done_vidx),
    .upd_valid(upd_valid), .upd_dst(upd_dst), .upd_val(upd_val),
    .s3_valid(s3_valid), .s3_addr(s3_addr), .s3_data(s3_data)
  );
endmodule

// File: rtl/sgp_pipe_checker.sv
module sgp_pipe_checker #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode,
  input logic          in_valid,
  input logic          in_ready,
  input logic [AW-1:0] rd_addr,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          upd_valid,
  input logic          done_valid
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R2
  scatter_update_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !mode) |-> ##2 upd_valid);

  // R3
  scatter_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !mode) |-> ##2 (!wr_en && !done_valid));

  // R4
  gather_write_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode) |-> ##2 (wr_en && done_valid && (wr_addr == $past(rd_addr, 2))));

  // R5
  gather_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode) |-> ##2 !upd_valid);

  // R7
  mode_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc) && (mode != $past(mode))) |-> !in_ready);
endmodule

bind sgp_vertex_pipe sgp_pipe_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
  .in_ready(in_ready), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
  .upd_valid(upd_valid), .done_valid(done_valid)
);

// File: tb/sgp_vertex_pipe_bench.sv
module sgp_vertex_pipe_bench;
  localparam int IV_LOG2 = 4;
  localparam int PART_W  = 8;
  localparam int AW      = IV_LOG2;
  localparam int DEPTH   = 1 << IV_LOG2;
  localparam int PART    = 2;
  localparam logic [31:0] BASE = 32'(PART * DEPTH);
  localparam int NVEC = 12;
  // {mode, src, dst, val}
  localparam logic [96:0] VEC [NVEC] = '{
    {1'b0, 32'd33, 32'd40, 32'd5},
    {1'b0, 32'd34, 32'd35, 32'd7},
    {1'b0, 32'd47, 32'd33, 32'hFFFF_FFFF},
    {1'b1, 32'd0,  32'd36, 32'd10},
    {1'b1, 32'd0,  32'd36, 32'd20},
    {1'b1, 32'd0,  32'd37, 32'd3},
    {1'b1, 32'd0,  32'd36, 32'hFFFF_FFF0},
    {1'b1, 32'd0,  32'd37, 32'd1},
    {1'b0, 32'd36, 32'd41, 32'd2},
    {1'b0, 32'd37, 32'd42, 32'd1},
    {1'b1, 32'd0,  32'd32, 32'd9},
    {1'b0, 32'd32, 32'd45, 32'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0, in_valid = 1'b0;
  logic [PART_W-1:0] part_idx = PART_W'(PART);
  logic [31:0] in_src = '0, in_dst = '0, in_val = '0;
  logic in_ready, rd_en, wr_en, upd_valid, done_valid;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data, upd_dst, upd_val, done_vidx;

  logic [31:0] mem [DEPTH];
  logic [31:0] refm [DEPTH];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] q_ud[$], q_uv[$];
  int q_uc[$];
  logic [31:0] q_wd[$], q_wv[$];
  logic [AW-1:0] q_wa[$];
  int q_wc[$];
  string q_wt[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial for (int i = 0; i < DEPTH; i++) begin
    mem[i]  = 32'(i * 3 + 1);
    refm[i] = 32'(i * 3 + 1);
  end

  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  sgp_vertex_pipe #(.IV_LOG2(IV_LOG2), .PART_W(PART_W)) u_sgp_vertex_pipe (
    .clk(clk), .rst_n(rst_n), .mode(mode), .part_idx(part_idx),
    .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src), .in_dst(in_dst),
    .in_val(in_val), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd_valid(upd_valid), .upd_dst(upd_dst), .upd_val(upd_val),
    .done_valid(done_valid), .done_vidx(done_vidx)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: results due two rising edges after acceptance
  always @(negedge clk) if (rst_n && !finished) begin
    chk(!(upd_valid && wr_en), "R3", "update and write together", 1, 0);
    chk(done_valid == wr_en, "R4", "done_valid vs wr_en", done_valid, wr_en);
    if (upd_valid) begin
      if (q_ud.size() == 0) chk(0, "R5", "unexpected update", upd_dst, 0);
      else begin
        chk(upd_dst == q_ud[0], "R2", "upd_dst", upd_dst, q_ud[0]);
        chk(upd_val == q_uv[0], "R2", "upd_val", upd_val, q_uv[0]);
        chk(cyc == q_uc[0], "R2", "update cycle", cyc, q_uc[0]);
        void'(q_ud.pop_front()); void'(q_uv.pop_front()); void'(q_uc.pop_front());
      end
    end
    if (wr_en) begin
      if (q_wd.size() == 0) chk(0, "R3", "unexpected write", wr_addr, 0);
      else begin
        chk(wr_addr == q_wa[0], q_wt[0], "wr_addr", wr_addr, q_wa[0]);
        chk(wr_data == q_wv[0], q_wt[0], "wr_data", wr_data, q_wv[0]);
        chk(done_vidx == q_wd[0], q_wt[0], "done_vidx", done_vidx, q_wd[0]);
        chk(cyc == q_wc[0], q_wt[0], "write cycle", cyc, q_wc[0]);
        void'(q_wd.pop_front()); void'(q_wv.pop_front()); void'(q_wa.pop_front());
        void'(q_wc.pop_front()); void'(q_wt.pop_front());
      end
    end
  end

  task automatic send(input logic m, input logic [31:0] s, input logic [31:0] d,
                      input logic [31:0] v, input string tag, output int stalls);
    logic [AW-1:0] a;
    stalls = 0;
    @(negedge clk);
    mode = m; in_src = s; in_dst = d; in_val = v; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    a = m ? AW'(d - BASE) : AW'(s - BASE);
    chk(rd_en == 1'b1, m ? "R4" : "R2", "rd_en", rd_en, 1);
    chk(rd_addr == a, m ? "R4" : "R2", "rd_addr", rd_addr, a);
    if (!m) begin
      q_ud.push_back(d); q_uv.push_back(v * refm[a]); q_uc.push_back(cyc + 2);
    end else begin
      refm[a] = refm[a] + v;
      q_wd.push_back(d); q_wv.push_back(refm[a]); q_wa.push_back(a);
      q_wc.push_back(cyc + 2); q_wt.push_back(tag);
    end
  endtask

  initial begin
    int st, total_st, exp_st;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!upd_valid && !wr_en && !done_valid && !rd_en, "R1", "outputs idle in reset",
        {upd_valid, wr_en, done_valid, rd_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(!upd_valid && !wr_en && !done_valid, "R1", "outputs idle after reset",
        {upd_valid, wr_en, done_valid}, 0);

    // vector table: R2 R4 R6 R9 and read-back of gathered values
    total_st = 0; exp_st = 0;
    for (int i = 0; i < NVEC; i++) begin
      if (i > 0 && VEC[i][96] != VEC[i-1][96]) exp_st += 2;
      send(VEC[i][96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0],
           (VEC[i][63:32] == 32'd36 || VEC[i][63:32] == 32'd37) ? "R6" : "R4", st);
      total_st += st;
    end
    // R8 and R7: only mode switches cost wait cycles, two each
    chk(total_st == exp_st, "R8", "wait cycles in table", total_st, exp_st);

    // R7: directed switch gather -> scatter on the same vertex
    send(1'b1, 32'd0, 32'd38, 32'd4, "R4", st);
    send(1'b0, 32'd38, 32'd50, 32'd1, "R7", st);
    chk(st == 2, "R7", "wait cycles on mode switch", st, 2);

    // R9: explicit wrap of a product
    send(1'b0, 32'd39, 32'd51, 32'h8000_0001, "R9", st);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(q_ud.size() == 0, "R2", "updates outstanding", q_ud.size(), 0);
    chk(q_wd.size() == 0, "R4", "writes outstanding", q_wd.size(), 0);
    chk(mem[6] == 32'd23, "R4", "buffer holds gathered sum", mem[6], 23);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule